// File: doc/BRIEF.md
# Cartridge Bank Register Controller

This block sits between a game console's CPU bus and the banked memories of a cartridge. It watches CPU writes in the upper half of the address space and keeps a control byte and four character-bank numbers. From these it drives the upper address lines of a program flash (one switchable 32 KiB bank visible at the whole upper CPU window) and the upper address lines of a 32 KiB character RAM.

The character RAM is split into four 2 KiB windows. The PPU address bits A12:A11 pick a window, and that window's register supplies the bank number. The character-RAM address is the bank number followed by PPU A10:A0.

The control byte also holds an active-low select for an external sound chip and a stop flag for an external scanline counter. Writes to the sound chip's and the counter's address ranges come out as decoded, active-low strobes. Every register is written on the falling edge of M2 while CPU R/W is low.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While reset is low, `prg_hi` is 0, `snd_cs_n` is 0 and `irq_stop` is 0. The four character-bank registers for windows 0, 1, 2 and 3 hold 0, 1, 2 and 3.
- R2: A write (R/W low at the falling edge of M2) with A15:A13 = 100 loads data bits 3:0 into `prg_hi`. The new value is visible right after that edge.
- R3: The same control write copies data bit 6 to `snd_cs_n`.
- R4: The same control write copies data bit 7 to `irq_stop`.
- R5: Data bits 5:4 of a control write have no effect on any output.
- R6: A cycle with R/W high changes no register.
- R7: A write with A15:A13 = 111 loads data bits 3:0 into the character-bank register indexed by CPU A1:A0. The other address bits are ignored.
- R8: `chr_hi` follows, without a clock, the bank register of the window chosen by PPU A12:A11.
- R9: `snd_wr_n` is low exactly while M2 is high, R/W is low and A15:A13 = 101. `snd_a0` always equals CPU A0, where 0 selects the data port and 1 selects the control port.
- R10: `irq_wr_n` is low exactly while M2 is high, R/W is low and A15:A13 = 110.
- R11: Writes outside 100 and 111 in A15:A13 leave `prg_hi`, `snd_cs_n`, `irq_stop` and all four character banks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | CPU M2 phase; registers load on its falling edge |
| cpu_rw | input | 1 | CPU R/W, low for a write |
| cpu_a | input | 16 | CPU address |
| cpu_d | input | 8 | CPU data |
| ppu_a | input | 13 | PPU address A12:A0 |
| prg_hi | output | 4 | Program-flash address bits A18:A15 |
| chr_hi | output | 4 | Character-RAM address bits A14:A11 |
| snd_cs_n | output | 1 | Sound chip select, active low |
| snd_wr_n | output | 1 | Sound chip write strobe, active low |
| snd_a0 | output | 1 | Sound chip port select (0 data, 1 control) |
| irq_wr_n | output | 1 | Scanline counter load strobe, active low |
| irq_stop | output | 1 | Stops the scanline counter when high |

## Verification
Two functions can act in the same cycle: a CPU write to a character-bank register, and PPU fetches through the window that register serves. The bench writes to $E002 and $E003 while PPU A12:A11 already points at windows 2 and 3. It checks that `chr_hi` keeps the old bank during the M2-high phase and shows the new bank right after the falling edge. A behavioural model in the bench holds plain integers for the control fields and the bank list. Every clock it predicts every output from the requirements and compares all of them.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int PRG_W = 4,
  parameter int CHR_W = 4,
  parameter int WIN_W = 2
) (
  input  logic             rst_n,
  input  logic             m2,
  input  logic             cpu_rw,
  input  logic [15:0]      cpu_a,
  input  logic [7:0]       cpu_d,
  input  logic [12:0]      ppu_a,
  output logic [PRG_W-1:0] prg_hi,
  output logic [CHR_W-1:0] chr_hi,
  output logic             snd_cs_n,
  output logic             snd_wr_n,
  output logic             snd_a0,
  output logic             irq_wr_n,
  output logic             irq_stop
);
  localparam int NWIN   = 1 << WIN_W;
  localparam int WIN_LO = 13 - WIN_W;

  logic [PRG_W-1:0] prg_q;
  logic             cs_q, stop_q;
  logic [CHR_W-1:0] chr_q [NWIN];

  wire sel_ctrl = cpu_a[15:13] == 3'b100;
  wire sel_snd  = cpu_a[15:13] == 3'b101;
  wire sel_irq  = cpu_a[15:13] == 3'b110;
  wire sel_chr  = cpu_a[15:13] == 3'b111;
  wire wr_phase = m2 & ~cpu_rw;

  logic unused_bits;
  assign unused_bits = ^{cpu_d[5:4], cpu_a[12:WIN_W], ppu_a[WIN_LO-1:0]};

  always_ff @(negedge m2 or negedge rst_n) begin
    if (!rst_n) begin
      prg_q  <= '0;
      cs_q   <= 1'b0;
      stop_q <= 1'b0;
      for (int i = 0; i < NWIN; i++) chr_q[i] <= CHR_W'(i);
    end else if (!cpu_rw) begin
      if (sel_ctrl) begin
        prg_q  <= cpu_d[PRG_W-1:0];
        cs_q   <= cpu_d[6];
        stop_q <= cpu_d[7];
      end
      if (sel_chr) chr_q[cpu_a[WIN_W-1:0]] <= cpu_d[CHR_W-1:0];
    end
  end

  assign prg_hi   = prg_q;
  assign snd_cs_n = cs_q;
  assign irq_stop = stop_q;
  assign chr_hi   = chr_q[ppu_a[12:WIN_LO]];
  assign snd_wr_n = ~(wr_phase & sel_snd);
  assign irq_wr_n = ~(wr_phase & sel_irq);
  assign snd_a0   = cpu_a[0];
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk (
  input logic        rst_n,
  input logic        m2,
  input logic        cpu_rw,
  input logic [15:0] cpu_a,
  input logic [7:0]  cpu_d,
  input logic [3:0]  prg_hi,
  input logic        snd_cs_n,
  input logic        snd_wr_n,
  input logic        irq_wr_n,
  input logic        irq_stop
);
  p_reset_r1: assert property (@(posedge m2) !rst_n |-> (prg_hi == 4'd0 && !snd_cs_n && !irq_stop))
    else $error("p_reset_r1");

  p_prg_load_r2: assert property (@(negedge m2) disable iff (!rst_n)
    (!cpu_rw && cpu_a[15:13] == 3'b100) |=> prg_hi == $past(cpu_d[3:0]))
    else $error("p_prg_load_r2");

  p_cs_load_r3: assert property (@(negedge m2) disable iff (!rst_n)
    (!cpu_rw && cpu_a[15:13] == 3'b100) |=> snd_cs_n == $past(cpu_d[6]))
    else $error("p_cs_load_r3");

  p_stop_load_r4: assert property (@(negedge m2) disable iff (!rst_n)
    (!cpu_rw && cpu_a[15:13] == 3'b100) |=> irq_stop == $past(cpu_d[7]))
    else $error("p_stop_load_r4");

  p_read_hold_r6: assert property (@(negedge m2) disable iff (!rst_n)
    cpu_rw |=> ($stable(prg_hi) && $stable(snd_cs_n) && $stable(irq_stop)))
    else $error("p_read_hold_r6");

  p_snd_strobe_r9: assert property (@(negedge m2) disable iff (!rst_n)
    !snd_wr_n |-> (!cpu_rw && cpu_a[15:13] == 3'b101))
    else $error("p_snd_strobe_r9");

  p_irq_strobe_r10: assert property (@(negedge m2) disable iff (!rst_n)
    !irq_wr_n |-> (!cpu_rw && cpu_a[15:13] == 3'b110))
    else $error("p_irq_strobe_r10");

  p_strobe_excl_r10: assert property (@(negedge m2) disable iff (!rst_n)
    $countones({~snd_wr_n, ~irq_wr_n}) <= 1)
    else $error("p_strobe_excl_r10");
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk u_chk (
  .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw), .cpu_a(cpu_a), .cpu_d(cpu_d),
  .prg_hi(prg_hi), .snd_cs_n(snd_cs_n), .snd_wr_n(snd_wr_n),
  .irq_wr_n(irq_wr_n), .irq_stop(irq_stop)
);

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpu_rw = 1'b1;
  logic [15:0] cpu_a = 16'h0000;
  logic [7:0]  cpu_d = 8'h00;
  logic [12:0] ppu_a = 13'h0000;
  logic [3:0]  prg_hi, chr_hi;
  logic        snd_cs_n, snd_wr_n, snd_a0, irq_wr_n, irq_stop;

  cart_bank_ctrl u_dut (
    .rst_n(rst_n), .m2(clk), .cpu_rw(cpu_rw), .cpu_a(cpu_a), .cpu_d(cpu_d),
    .ppu_a(ppu_a), .prg_hi(prg_hi), .chr_hi(chr_hi), .snd_cs_n(snd_cs_n),
    .snd_wr_n(snd_wr_n), .snd_a0(snd_a0), .irq_wr_n(irq_wr_n), .irq_stop(irq_stop)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  int m_prg, m_cs, m_stop;
  int m_bank [4];

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prg = 0; m_cs = 0; m_stop = 0;
      for (int i = 0; i < 4; i++) m_bank[i] = i;
    end else if (cpu_rw == 1'b0) begin
      if (cpu_a >= 16'h8000 && cpu_a < 16'hA000) begin
        m_prg  = cpu_d & 8'h0F;
        m_cs   = (cpu_d >> 6) & 1;
        m_stop = (cpu_d >> 7) & 1;
      end
      if (cpu_a >= 16'hE000) m_bank[cpu_a % 4] = cpu_d & 8'h0F;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int wr, hi;
    wr = (cpu_rw == 1'b0);
    hi = cpu_a[15:13];
    chk("R2 prg_hi", prg_hi, m_prg);
    chk("R3 snd_cs_n", snd_cs_n, m_cs);
    chk("R4 irq_stop", irq_stop, m_stop);
    chk("R8 chr_hi", chr_hi, m_bank[ppu_a / 2048]);
    chk("R9 snd_wr_n", snd_wr_n, (clk && wr && hi == 5) ? 0 : 1);
    chk("R9 snd_a0", snd_a0, cpu_a % 2);
    chk("R10 irq_wr_n", irq_wr_n, (clk && wr && hi == 6) ? 0 : 1);
  endtask

  task automatic cyc(input bit rw, input logic [15:0] a, input logic [7:0] d, input logic [12:0] p);
    @(posedge clk);
    cpu_rw = rw; cpu_a = a; cpu_d = d; ppu_a = p;
    #1 compare_all();
  endtask

  task automatic sweep_windows();
    for (int w = 0; w < 4; w++) cyc(1'b1, 16'h0000, 8'h00, 13'(w * 2048 + 17));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    phase = "R1";
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); ppu_a = 13'(i * 2048); #1 compare_all();
      chk("R1 bank reset", chr_hi, i);
    end
    @(posedge clk); rst_n = 1'b1;
    sweep_windows();

    phase = "R2";
    cyc(1'b0, 16'h8000, 8'h05, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    chk("R2 bank 5", prg_hi, 5);
    cyc(1'b0, 16'h9FFF, 8'h0A, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    cyc(1'b0, 16'h8123, 8'h0F, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);

    phase = "R3";
    cyc(1'b0, 16'h8000, 8'h43, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    chk("R3 cs high", snd_cs_n, 1);

    phase = "R4";
    cyc(1'b0, 16'h8000, 8'h81, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    chk("R4 stop high", irq_stop, 1);

    phase = "R5";
    cyc(1'b0, 16'h8000, 8'h37, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    chk("R5 reserved ignored", {irq_stop, snd_cs_n, prg_hi}, 7);
    cyc(1'b0, 16'h8000, 8'hF2, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    chk("R5 reserved ignored", {irq_stop, snd_cs_n, prg_hi}, 6'h32);

    phase = "R6";
    cyc(1'b1, 16'h8000, 8'h0C, 13'h0000);
    cyc(1'b1, 16'hE001, 8'h0C, 13'h0800);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0800);
    chk("R6 read no write", prg_hi, 2);
    sweep_windows();

    phase = "R7";
    cyc(1'b0, 16'hE000, 8'hF9, 13'h0000);
    cyc(1'b0, 16'hE001, 8'h0E, 13'h0000);
    cyc(1'b0, 16'hFFFE, 8'h07, 13'h0000);
    cyc(1'b0, 16'hF7F7, 8'h0C, 13'h0000);
    sweep_windows();

    phase = "R8 same cycle";
    cyc(1'b0, 16'hE002, 8'h0B, 13'h1000);
    chk("R8 old bank during write", chr_hi, 7);
    cyc(1'b1, 16'h0000, 8'h00, 13'h1000);
    chk("R8 new bank after edge", chr_hi, 11);
    cyc(1'b0, 16'hE003, 8'h01, 13'h1FFF);
    cyc(1'b1, 16'h0000, 8'h00, 13'h1FFF);
    chk("R8 new bank after edge", chr_hi, 1);

    phase = "R9";
    cyc(1'b0, 16'hA000, 8'h90, 13'h0000);
    chk("R9 data port strobe", {snd_wr_n, snd_a0}, 0);
    cyc(1'b0, 16'hA001, 8'h7F, 13'h0000);
    chk("R9 control port strobe", {snd_wr_n, snd_a0}, 1);
    cyc(1'b1, 16'hA000, 8'h00, 13'h0000);
    cyc(1'b0, 16'hBFFF, 8'h00, 13'h0000);

    phase = "R10";
    cyc(1'b0, 16'hC000, 8'h20, 13'h0000);
    chk("R10 counter strobe", irq_wr_n, 0);
    cyc(1'b1, 16'hC000, 8'h20, 13'h0000);
    cyc(1'b0, 16'hDFFF, 8'h03, 13'h0000);

    phase = "R11";
    cyc(1'b0, 16'h0000, 8'hFF, 13'h0000);
    cyc(1'b0, 16'h6003, 8'hFF, 13'h0000);
    cyc(1'b0, 16'h7FFF, 8'hFF, 13'h0000);
    cyc(1'b0, 16'hA002, 8'hFF, 13'h0000);
    cyc(1'b0, 16'hC001, 8'hFF, 13'h0000);
    cyc(1'b1, 16'h0000, 8'h00, 13'h0000);
    chk("R11 ctrl kept", prg_hi, 2);
    sweep_windows();

    phase = "R1 again";
    @(posedge clk); rst_n = 1'b0; #1 compare_all();
    chk("R1 prg reset", prg_hi, 0);
    @(posedge clk); rst_n = 1'b1;
    sweep_windows();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule